// File: doc/BRIEF.md
# Double-Buffered Output Gamma Table

This block applies an output gamma curve to an RGB pixel stream. It holds two lookup banks, A and B. One bank serves pixels while a host loads a new curve into the other through a small register port. After the load, the host points the select field at the new bank, and the change takes effect at the next frame-start pulse. Every channel maps its input code through a piecewise-linear curve. The input splits into a segment number and a fraction, and the output blends the two table entries on either side of that point.

The host port has four word addresses: control, LUT control, index and data. A curve of N segments needs N+1 entries per channel, because the final entry closes the top segment. The host loads it as a burst: it clears the index, then writes the data register N+1 times. A three-bit colour mask selects which channels take each data write. The host can therefore load one shared curve in a single burst, or three separate curves in three bursts. The mode and bank that are actually in effect are reported on two readback outputs.

Top module: `gamma_pingpong_lut`

## Requirements
- R1: After reset, cur_mode_o is 0, cur_sel_o is 0 and pix_valid_o is 0. Internally, the colour mask is 7, the host bank is A and the write pointer is 0.
- R2: pix_valid_o follows pix_valid_i after exactly one clock. In mode 0 (bypass), and in the reserved modes 1 and 3, each output channel equals its input channel, delayed by one clock.
- R3: In mode 2 (lookup), pixels are looked up in bank A when the current select bit is 0 and in bank B when it is 1.
- R4: A write to the control register (address 0: mode in bits 1:0, select in bit 2) is held pending. It reaches cur_mode_o, cur_sel_o and the pixel path on the clock edge that samples frame_start_i high. A pixel sampled on that same edge still uses the previous setting.
- R5: Bit 3 of the LUT control register (address 1) picks the bank the host writes: 0 for A, 1 for B. This choice does not affect which bank serves pixels.
- R6: Bits 2:0 of the LUT control register form a write mask: bit 2 for red, bit 1 for green, bit 0 for blue. A data write updates only the channels whose mask bit is set.
- R7: A write to address 2 loads the write pointer. A write to address 3 stores its value at the pointer and adds one to the pointer, but only while the pointer is below N+1. At or above N+1 the data write is dropped and the pointer holds, so nothing wraps.
- R8: In lookup mode, with s = the upper SEG_BITS bits of the input, f = the low PIX_W-SEG_BITS bits (F of them), lo = entry s and hi = entry s+1, the output is floor((lo*2^F + (hi-lo)*f + 2^(F-1)) / 2^F).
- R9: A lookup result above 2^PIX_W-1 is clamped to 2^PIX_W-1. Table entries are ENT_W bits wide, which is wider than a pixel.
- R10: A data write is ignored when the mode in effect is 2 and the host bank equals the current select bit. The pointer still advances, so the serving bank's output never changes.
- R11: Entry N is used as the upper endpoint of the top segment. It affects outputs for input codes in the top segment with a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | 2 | Register address: 0 control, 1 LUT control, 2 index, 3 data |
| host_data_i | input | ENT_W | Host write data |
| frame_start_i | input | 1 | Frame boundary pulse; applies the pending mode and select |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | PIX_W | Red input |
| pix_g_i | input | PIX_W | Green input |
| pix_b_i | input | PIX_W | Blue input |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | PIX_W | Red output |
| pix_g_o | output | PIX_W | Green output |
| pix_b_o | output | PIX_W | Blue output |
| cur_mode_o | output | 2 | Mode currently in effect |
| cur_sel_o | output | 1 | Bank currently serving pixels |

## Verification
The write pointer is hard to observe from the ports. Its position after dropped writes and at the end of the table can only be seen through lookups made after a later bank swap. The stimulus first makes three writes that hit the serving bank and are ignored. It then redirects the host to the idle bank and makes one more write, which must land at entry 3. It then starts a burst at the last entry and runs past it, checking that the end entry changed and entry 0 did not. Pixels run through the whole load, so a write that leaks into the serving bank shows up at once in the per-clock comparison.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_RSV1   = 2'd1,
    MODE_LUT    = 2'd2,
    MODE_RSV3   = 2'd3
  } gmode_e;

  localparam int unsigned NUM_CH    = 3;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned CH_R      = 2;
  localparam int unsigned CH_G      = 1;
  localparam int unsigned CH_B      = 0;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LCTL = 2'd1;
  localparam logic [1:0] ADDR_IDX  = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;
endpackage

// File: rtl/gamma_host_if.sv
module gamma_host_if
  import gamma_pkg::*;
#(
  parameter int unsigned ENT_W = 11,
  parameter int unsigned DEPTH = 17,
  parameter int unsigned IDX_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [ENT_W-1:0]     wr_data_i,
  input  logic                 frame_start_i,
  output gmode_e               cur_mode_o,
  output logic                 cur_sel_o,
  output logic [NUM_BANKS-1:0] bank_we_o,
  output logic [NUM_CH-1:0]    ch_mask_o,
  output logic [IDX_W-1:0]     wr_idx_o,
  output logic [ENT_W-1:0]     wr_val_o
);
  gmode_e            pend_mode_q, cur_mode_q;
  logic              pend_sel_q, cur_sel_q;
  logic [NUM_CH-1:0] mask_q;
  logic              hsel_q;
  logic [IDX_W-1:0]  ptr_q;

  logic data_wr, in_range, live_hit;
  assign data_wr  = wr_en_i && (wr_addr_i == ADDR_DATA);
  assign in_range = (ptr_q < IDX_W'(DEPTH));
  // the bank feeding pixels is write-protected
  assign live_hit = (cur_mode_q == MODE_LUT) && (hsel_q == cur_sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_mode_q <= MODE_BYPASS;
      pend_sel_q  <= 1'b0;
      cur_mode_q  <= MODE_BYPASS;
      cur_sel_q   <= 1'b0;
      mask_q      <= '1;
      hsel_q      <= 1'b0;
      ptr_q       <= '0;
    end else begin
      if (wr_en_i) begin
        case (wr_addr_i)
          ADDR_CTRL: begin
            pend_mode_q <= gmode_e'(wr_data_i[1:0]);
            pend_sel_q  <= wr_data_i[2];
          end
          ADDR_LCTL: begin
            mask_q <= wr_data_i[NUM_CH-1:0];
            hsel_q <= wr_data_i[3];
          end
          ADDR_IDX:  ptr_q <= wr_data_i[IDX_W-1:0];
          default:   if (in_range) ptr_q <= ptr_q + 1'b1;
        endcase
      end
      if (frame_start_i) begin
        cur_mode_q <= pend_mode_q;
        cur_sel_q  <= pend_sel_q;
      end
    end
  end

  for (genvar bk = 0; bk < NUM_BANKS; bk++) begin : g_we
    assign bank_we_o[bk] = data_wr && in_range && !live_hit && (hsel_q == 1'(bk));
  end

  assign cur_mode_o = cur_mode_q;
  assign cur_sel_o  = cur_sel_q;
  assign ch_mask_o  = mask_q;
  assign wr_idx_o   = ptr_q;
  assign wr_val_o   = wr_data_i;

  p_hold_until_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> ($stable(cur_mode_q) && $stable(cur_sel_q)));
  p_ptr_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !in_range) |=> $stable(ptr_q));
  p_one_bank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we_o));
endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank
  import gamma_pkg::*;
#(
  parameter int unsigned ENT_W    = 11,
  parameter int unsigned SEG_BITS = 4,
  parameter int unsigned DEPTH    = 17,
  parameter int unsigned IDX_W    = 5
) (
  input  logic                             clk_i,
  input  logic                             we_i,
  input  logic [NUM_CH-1:0]                mask_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [ENT_W-1:0]                 wr_val_i,
  input  logic [NUM_CH-1:0][SEG_BITS-1:0]  seg_i,
  output logic [NUM_CH-1:0][ENT_W-1:0]     lo_o,
  output logic [NUM_CH-1:0][ENT_W-1:0]     hi_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0] lo_idx, hi_idx;

    always_ff @(posedge clk_i) begin
      if (we_i && mask_i[ch]) mem_q[wr_idx_i] <= wr_val_i;
    end

    assign lo_idx   = IDX_W'(seg_i[ch]);
    assign hi_idx   = lo_idx + 1'b1;
    assign lo_o[ch] = mem_q[lo_idx];
    assign hi_o[ch] = mem_q[hi_idx];
  end
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp #(
  parameter int unsigned ENT_W  = 11,
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned OUT_W  = 10
) (
  input  logic [ENT_W-1:0]  lo_i,
  input  logic [ENT_W-1:0]  hi_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [OUT_W-1:0]  y_o
);
  localparam int unsigned ACC_W = ENT_W + FRAC_W + 3;
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((1 << OUT_W) - 1);
  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1 << (FRAC_W - 1));

  logic signed [ACC_W-1:0] base_w, diff_w, frac_w, acc, quo;

  always_comb begin
    base_w = $signed(ACC_W'({lo_i, {FRAC_W{1'b0}}}));
    diff_w = $signed(ACC_W'(hi_i)) - $signed(ACC_W'(lo_i));
    frac_w = $signed(ACC_W'(frac_i));
    acc    = base_w + diff_w * frac_w + HALF;
    quo    = acc >>> FRAC_W;
    if (quo > OUT_MAX)                   y_o = '1;
    else if (quo < $signed(ACC_W'(0)))   y_o = '0;
    else                                 y_o = quo[OUT_W-1:0];
  end
endmodule

// File: rtl/gamma_pingpong_lut.sv
module gamma_pingpong_lut
  import gamma_pkg::*;
#(
  parameter int unsigned PIX_W    = 10,
  parameter int unsigned SEG_BITS = 4,
  parameter int unsigned ENT_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_wr_i,
  input  logic [1:0]       host_addr_i,
  input  logic [ENT_W-1:0] host_data_i,
  input  logic             frame_start_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_r_i,
  input  logic [PIX_W-1:0] pix_g_i,
  input  logic [PIX_W-1:0] pix_b_i,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_r_o,
  output logic [PIX_W-1:0] pix_g_o,
  output logic [PIX_W-1:0] pix_b_o,
  output logic [1:0]       cur_mode_o,
  output logic             cur_sel_o
);
  localparam int unsigned NSEG   = 1 << SEG_BITS;
  localparam int unsigned DEPTH  = NSEG + 1;
  localparam int unsigned IDX_W  = $clog2(DEPTH + 1);
  localparam int unsigned FRAC_W = PIX_W - SEG_BITS;

  gmode_e                                    cur_mode;
  logic                                      cur_sel;
  logic [NUM_BANKS-1:0]                      bank_we;
  logic [NUM_CH-1:0]                         ch_mask;
  logic [IDX_W-1:0]                          wr_idx;
  logic [ENT_W-1:0]                          wr_val;
  logic [NUM_CH-1:0][PIX_W-1:0]              pix_in, pix_lut, pix_d, pix_q;
  logic [NUM_CH-1:0][SEG_BITS-1:0]           seg;
  logic [NUM_BANKS-1:0][NUM_CH-1:0][ENT_W-1:0] lo_b, hi_b;
  logic                                      valid_q;
  logic                                      lut_on;

  gamma_host_if #(.ENT_W(ENT_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_host (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (host_wr_i),
    .wr_addr_i    (host_addr_i),
    .wr_data_i    (host_data_i),
    .frame_start_i(frame_start_i),
    .cur_mode_o   (cur_mode),
    .cur_sel_o    (cur_sel),
    .bank_we_o    (bank_we),
    .ch_mask_o    (ch_mask),
    .wr_idx_o     (wr_idx),
    .wr_val_o     (wr_val)
  );

  assign pix_in[CH_R] = pix_r_i;
  assign pix_in[CH_G] = pix_g_i;
  assign pix_in[CH_B] = pix_b_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_seg
    assign seg[ch] = pix_in[ch][PIX_W-1 -: SEG_BITS];
  end

  for (genvar bk = 0; bk < NUM_BANKS; bk++) begin : g_bank
    gamma_lut_bank #(.ENT_W(ENT_W), .SEG_BITS(SEG_BITS), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_bank (
      .clk_i   (clk_i),
      .we_i    (bank_we[bk]),
      .mask_i  (ch_mask),
      .wr_idx_i(wr_idx),
      .wr_val_i(wr_val),
      .seg_i   (seg),
      .lo_o    (lo_b[bk]),
      .hi_o    (hi_b[bk])
    );
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_interp
    gamma_interp #(.ENT_W(ENT_W), .FRAC_W(FRAC_W), .OUT_W(PIX_W)) u_interp (
      .lo_i  (lo_b[cur_sel][ch]),
      .hi_i  (hi_b[cur_sel][ch]),
      .frac_i(pix_in[ch][FRAC_W-1:0]),
      .y_o   (pix_lut[ch])
    );
  end

  // reserved modes fall through to bypass
  assign lut_on = (cur_mode == MODE_LUT);
  assign pix_d  = lut_on ? pix_lut : pix_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      valid_q <= pix_valid_i;
      if (pix_valid_i) pix_q <= pix_d;
    end
  end

  assign pix_valid_o = valid_q;
  assign pix_r_o     = pix_q[CH_R];
  assign pix_g_o     = pix_q[CH_G];
  assign pix_b_o     = pix_q[CH_B];
  assign cur_mode_o  = cur_mode;
  assign cur_sel_o   = cur_sel;

  p_valid_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pix_valid_o == $past(pix_valid_i)));
  p_bypass_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && cur_mode_o != 2'd2) |=>
      (pix_r_o == $past(pix_r_i) && pix_g_o == $past(pix_g_i) && pix_b_o == $past(pix_b_i)));
  p_no_live_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mode_o == 2'd2) |-> !bank_we[cur_sel_o]);
  p_sel_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(cur_sel_o));
endmodule

// File: tb/test_gamma_pingpong_lut.sv
module test_gamma_pingpong_lut;
  localparam int PIX_W = 10, SEG_BITS = 4, ENT_W = 11;
  localparam int DEPTH = (1 << SEG_BITS) + 1;
  localparam int FRAC_W = PIX_W - SEG_BITS;
  localparam int PMAX = (1 << PIX_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, frame_start = 1'b0, pix_valid = 1'b0;
  logic [1:0] host_addr = '0;
  logic [ENT_W-1:0] host_data = '0;
  logic [PIX_W-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic pix_valid_o, cur_sel_o;
  logic [PIX_W-1:0] pix_r_o, pix_g_o, pix_b_o;
  logic [1:0] cur_mode_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gamma_pingpong_lut #(.PIX_W(PIX_W), .SEG_BITS(SEG_BITS), .ENT_W(ENT_W)) i_gamma_pingpong_lut (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .host_data_i(host_data), .frame_start_i(frame_start), .pix_valid_i(pix_valid),
    .pix_r_i(pix_r), .pix_g_i(pix_g), .pix_b_i(pix_b), .pix_valid_o(pix_valid_o),
    .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o),
    .cur_mode_o(cur_mode_o), .cur_sel_o(cur_sel_o)
  );

  // reference model: channel index 2 red, 1 green, 0 blue
  int m_ram [2][3][DEPTH];
  int m_pend_mode, m_pend_sel, m_cur_mode, m_cur_sel, m_mask, m_hsel, m_ptr;
  int exp_valid, exp_px [3];
  string exp_tag;
  int old_mode, old_sel, x, s;

  function automatic int lut_eval(int lo, int hi, int f);
    int v;
    v = (lo * (1 << FRAC_W) + (hi - lo) * f + (1 << (FRAC_W - 1))) / (1 << FRAC_W);
    return (v > PMAX) ? PMAX : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend_mode = 0; m_pend_sel = 0; m_cur_mode = 0; m_cur_sel = 0;
      m_mask = 7; m_hsel = 0; m_ptr = 0; exp_valid = 0;
    end else begin
      exp_valid = pix_valid;
      if (pix_valid) begin
        exp_tag = (m_cur_mode == 2) ? "R8" : "R2";
        for (int ch = 0; ch < 3; ch++) begin
          x = (ch == 2) ? int'(pix_r) : (ch == 1) ? int'(pix_g) : int'(pix_b);
          s = x >> FRAC_W;
          if (m_cur_mode == 2)
            exp_px[ch] = lut_eval(m_ram[m_cur_sel][ch][s], m_ram[m_cur_sel][ch][s+1],
                                  x % (1 << FRAC_W));
          else exp_px[ch] = x;
        end
      end
      old_mode = m_cur_mode; old_sel = m_cur_sel;
      if (frame_start) begin m_cur_mode = m_pend_mode; m_cur_sel = m_pend_sel; end
      if (host_wr) begin
        case (host_addr)
          2'd0: begin m_pend_mode = host_data & 3; m_pend_sel = (host_data >> 2) & 1; end
          2'd1: begin m_mask = host_data & 7; m_hsel = (host_data >> 3) & 1; end
          2'd2: m_ptr = host_data & 31;
          default: if (m_ptr < DEPTH) begin
            if (!(old_mode == 2 && m_hsel == old_sel))
              for (int ch = 0; ch < 3; ch++)
                if ((m_mask >> ch) & 1) m_ram[m_hsel][ch][m_ptr] = host_data;
            m_ptr++;
          end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 valid", pix_valid_o, exp_valid);
      chk("R4 mode", cur_mode_o, m_cur_mode);
      chk("R4 sel", cur_sel_o, m_cur_sel);
      if (exp_valid) begin
        chk(exp_tag, pix_r_o, exp_px[2]);
        chk(exp_tag, pix_g_o, exp_px[1]);
        chk(exp_tag, pix_b_o, exp_px[0]);
      end
    end
  end

  task automatic step(input bit wr, input int addr, input int data, input bit pv,
                      input int r, input int g, input int b, input bit fs);
    host_wr = wr; host_addr = 2'(addr); host_data = ENT_W'(data);
    pix_valid = pv; pix_r = PIX_W'(r); pix_g = PIX_W'(g); pix_b = PIX_W'(b);
    frame_start = fs;
    @(negedge clk);
    host_wr = 0; pix_valid = 0; frame_start = 0;
  endtask

  task automatic hw(input int addr, input int data);
    step(1, addr, data, 0, 0, 0, 0, 0);
  endtask

  task automatic frame();
    step(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic px_lit(input string tag, input int v, input int er, input int eg, input int eb);
    step(0, 0, 0, 1, v, v, v, 0);
    chk(tag, pix_r_o, er);
    chk(tag, pix_g_o, eg);
    chk(tag, pix_b_o, eb);
  endtask

  task automatic noise(input int n);
    for (int i = 0; i < n; i++)
      step(0, 0, 0, 1'($urandom_range(0, 1)), $urandom_range(0, PMAX),
           $urandom_range(0, PMAX), $urandom_range(0, PMAX), 0);
  endtask

  task automatic load(input int curve);
    hw(2, 0);
    for (int i = 0; i < DEPTH; i++) begin
      int v;
      case (curve)
        0: v = i * i * 4;
        1: v = i * 100;
        2: v = 1000 - i * 50;
        default: v = i * 64 + 5;
      endcase
      step(1, 3, v, 1'($urandom_range(0, 1)), $urandom_range(0, PMAX), 512, $urandom_range(0, PMAX), 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 mode", cur_mode_o, 0);
    chk("R1 sel", cur_sel_o, 0);
    chk("R1 valid", pix_valid_o, 0);
    // R2 bypass
    px_lit("R2", 300, 300, 300, 300);
    noise(30);
    // load bank B with one shared curve (mask 7, host bank B)
    hw(1, 4'hF);
    load(0);
    hw(0, 6);
    chk("R4 pending", cur_mode_o, 0);
    px_lit("R4", 512, 512, 512, 512);
    frame();
    chk("R4 applied mode", cur_mode_o, 2);
    chk("R4 applied sel", cur_sel_o, 1);
    px_lit("R3", 512, 256, 256, 256);
    noise(40);
    // load bank A per channel while B serves (R5, R6)
    hw(1, 4); load(1);
    hw(1, 2); load(2);
    hw(1, 1); load(3);
    px_lit("R5", 512, 256, 256, 256);
    hw(0, 2);
    frame();
    px_lit("R6", 512, 800, 600, 517);
    px_lit("R8", 160, 250, 875, 165);
    px_lit("R9", 704, 1023, 450, 709);
    step(0, 0, 0, 1, 1023, 1023, 1023, 0);
    chk("R9", pix_r_o, 1023);
    chk("R11", pix_g_o, 201);
    noise(40);
    // R10: writes into the serving bank A are dropped but the pointer moves
    hw(1, 7); hw(2, 0);
    hw(3, 0); hw(3, 0); hw(3, 0);
    px_lit("R10 untouched", 0, 0, 1000, 5);
    hw(1, 4'hF); hw(3, 777);
    hw(0, 6); frame();
    px_lit("R10 pointer", 192, 777, 777, 777);
    px_lit("R10 neighbour", 128, 16, 16, 16);
    // R7: run past the end of bank A while B serves
    hw(1, 7); hw(2, 16);
    hw(3, 300); hw(3, 400); hw(3, 500);
    hw(0, 2); frame();
    step(0, 0, 0, 1, 1023, 1023, 1023, 0);
    chk("R7 end entry", pix_g_o, 299);
    px_lit("R7 no wrap", 0, 0, 1000, 5);
    noise(40);
    // reserved modes behave as bypass
    hw(0, 3); frame();
    chk("R2 reserved mode", cur_mode_o, 3);
    px_lit("R2 reserved 3", 300, 300, 300, 300);
    hw(0, 1); frame();
    px_lit("R2 reserved 1", 77, 77, 77, 77);
    noise(30);
    hw(0, 0); frame();
    noise(20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule